// File: doc/BRIEF.md
# Interior 3x3 Neighbourhood Sweeper

This block walks over a grayscale frame held in a synchronous single-port frame memory and hands a downstream gradient core one complete 3x3 neighbourhood at a time. It drives the memory's read address and collects the returned bytes into a 3x3 register window. For each window it presents the eight pixels that surround the centre, with a one-cycle valid strobe and the output coordinate where the result belongs.

Only neighbourhoods that lie fully inside the frame are produced. The outermost row and column on every side are never a centre, so a frame of width W and height H gives (W-2)x(H-2) windows. The default frame is 640x480, which gives 638x478 windows. A start pulse begins a sweep. A single-cycle done pulse closes it. Frame width and height are parameters.

Top module: `win3_sweeper`

## Requirements
- R1: After reset, `win_valid` and `done` are low and `mem_addr` is 0. With no start pulse, no window appears.
- R2: Read addresses are linear, address = row x IMG_W + column. Every address lies below IMG_W x IMG_H. The memory returns the byte for an address one cycle after it is presented.
- R3: Each window puts its eight neighbours on `win_pixels`, byte i at bits [8i+7:8i], in this order: 0 up-left, 1 up, 2 up-right, 3 left, 4 right, 5 down-left, 6 down, 7 down-right. The 8-bit pixel at (row, column) is the byte at address row x IMG_W + column.
- R4: Windows appear in raster order. `out_col` runs from 0 to IMG_W-3 and `out_row` runs from 0 to IMG_H-3. Output (c, r) is the window centred on pixel column c+1, row r+1.
- R5: One sweep produces exactly (IMG_W-2)x(IMG_H-2) windows.
- R6: `done` is high for exactly one cycle, the cycle right after the last window's `win_valid`.
- R7: A start pulse that arrives while a sweep is in progress, up to and including the done cycle, has no effect on the window sequence. No further window appears after `done`.
- R8: Within a row, consecutive windows are 3 cycles apart, because only the new right column is fetched. Between the last window of one row and the first window of the next, the gap is 9 cycles, because all nine pixels are fetched again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a sweep when the block is idle |
| mem_addr | output | $clog2(IMG_W*IMG_H) | Frame memory read address |
| mem_rd_data | input | 8 | Byte returned by the frame memory one cycle after the address |
| win_valid | output | 1 | One-cycle strobe: a window is present |
| win_pixels | output | 64 | Eight neighbour pixels, packed as in R3 |
| out_col | output | $clog2(IMG_W) | Output column of the window centre |
| out_row | output | $clog2(IMG_H) | Output row of the window centre |
| done | output | 1 | One-cycle pulse after the last window |

## Verification
The hardest conditions to reach from the ports are a start pulse that lands in the middle of a sweep and the boundary where the walk moves to a new row. At that boundary the window is rebuilt from scratch, and the new data must not mix with the previous row's columns. The bench raises start partway through selected sweeps and then checks every window's coordinates, all eight neighbour bytes and the gap since the previous window. This makes a restarted walk or a stale column show up at once. Frames alternate between seeded random content and directed flat-black, flat-white and ramp images, and the width is not a power of two, so address arithmetic errors are not masked.

// File: rtl/win3_pkg.sv
`timescale 1ns/1ps
package win3_pkg;
  typedef logic [7:0] pixel_t;

  // tag that travels alongside each read request
  typedef struct packed {
    logic       live;  // a read was issued
    logic [1:0] lane;  // 0 top, 1 middle, 2 bottom pixel of the column
    logic       emit;  // column completion produces a window
  } rd_tag_t;
endpackage

// File: rtl/win3_fetch_seq.sv
`timescale 1ns/1ps
module win3_fetch_seq
  import win3_pkg::*;
#(
  parameter int IMG_W  = 640,
  parameter int IMG_H  = 480,
  parameter int ADDR_W = $clog2(IMG_W * IMG_H),
  parameter int COL_W  = $clog2(IMG_W),
  parameter int ROW_W  = $clog2(IMG_H)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              sweep_end,
  output logic [ADDR_W-1:0] mem_addr,
  output rd_tag_t           tag_o
);
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(IMG_W - 1);
  localparam logic [ROW_W-1:0] CROW_LAST = ROW_W'(IMG_H - 2);

  logic             active, issuing;
  logic [COL_W-1:0] fcol;
  logic [ROW_W-1:0] crow;
  logic [1:0]       lane;
  logic [ADDR_W-1:0] pix_row, rd_addr;

  assign pix_row = ADDR_W'(crow) + ADDR_W'(lane) - ADDR_W'(1);
  assign rd_addr = pix_row * ADDR_W'(IMG_W) + ADDR_W'(fcol);

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      issuing  <= 1'b0;
      fcol     <= '0;
      crow     <= '0;
      lane     <= '0;
      mem_addr <= '0;
      tag_o    <= '0;
    end else begin
      tag_o <= '0;
      if (!active && start) begin
        active  <= 1'b1;
        issuing <= 1'b1;
        fcol    <= '0;
        crow    <= ROW_W'(1);
        lane    <= '0;
      end else if (sweep_end) begin
        active <= 1'b0;
      end
      if (issuing) begin
        mem_addr   <= rd_addr;
        tag_o.live <= 1'b1;
        tag_o.lane <= lane;
        tag_o.emit <= (lane == 2'd2) && (fcol >= COL_W'(2));
        if (lane == 2'd2) begin
          lane <= '0;
          if (fcol == COL_LAST) begin
            fcol <= '0;
            if (crow == CROW_LAST) issuing <= 1'b0;
            else                   crow    <= crow + 1'b1;
          end else begin
            fcol <= fcol + 1'b1;
          end
        end else begin
          lane <= lane + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/win3_window.sv
`timescale 1ns/1ps
module win3_window
  import win3_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  rd_tag_t     tag_i,
  input  pixel_t      rd_data,
  output logic [63:0] nbr_o,
  output logic        emit_o
);
  rd_tag_t tag_d;
  pixel_t  stage_top, stage_mid;
  pixel_t  col_in [3];
  pixel_t  win [3][3];  // [row][col], row 0 top, col 0 left
  logic    shift_en;

  assign shift_en  = tag_d.live && (tag_d.lane == 2'd2);
  assign col_in[0] = stage_top;
  assign col_in[1] = stage_mid;
  assign col_in[2] = rd_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      tag_d     <= '0;
      emit_o    <= 1'b0;
      stage_top <= '0;
      stage_mid <= '0;
    end else begin
      tag_d  <= tag_i;
      emit_o <= shift_en && tag_d.emit;
      if (tag_d.live && tag_d.lane == 2'd0) stage_top <= rd_data;
      if (tag_d.live && tag_d.lane == 2'd1) stage_mid <= rd_data;
    end
  end

  for (genvar gr = 0; gr < 3; gr++) begin : g_row
    always_ff @(posedge clk) begin
      if (rst) begin
        win[gr][0] <= '0;
        win[gr][1] <= '0;
        win[gr][2] <= '0;
      end else if (shift_en) begin
        win[gr][0] <= win[gr][1];
        win[gr][1] <= win[gr][2];
        win[gr][2] <= col_in[gr];
      end
    end
  end

  assign nbr_o = {win[2][2], win[2][1], win[2][0], win[1][2],
                  win[1][0], win[0][2], win[0][1], win[0][0]};
endmodule

// File: rtl/win3_emit.sv
`timescale 1ns/1ps
module win3_emit #(
  parameter int IMG_W = 640,
  parameter int IMG_H = 480,
  parameter int COL_W = $clog2(IMG_W),
  parameter int ROW_W = $clog2(IMG_H)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             emit_i,
  input  logic [63:0]      nbr_i,
  output logic             win_valid,
  output logic [63:0]      win_pixels,
  output logic [COL_W-1:0] out_col,
  output logic [ROW_W-1:0] out_row,
  output logic             done
);
  localparam logic [COL_W-1:0] OCOL_LAST = COL_W'(IMG_W - 3);
  localparam logic [ROW_W-1:0] OROW_LAST = ROW_W'(IMG_H - 3);

  logic [COL_W-1:0] ccnt;
  logic [ROW_W-1:0] rcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      win_valid  <= 1'b0;
      win_pixels <= '0;
      out_col    <= '0;
      out_row    <= '0;
      done       <= 1'b0;
      ccnt       <= '0;
      rcnt       <= '0;
    end else begin
      win_valid <= emit_i;
      done      <= win_valid && (out_col == OCOL_LAST) && (out_row == OROW_LAST);
      if (emit_i) begin
        win_pixels <= nbr_i;
        out_col    <= ccnt;
        out_row    <= rcnt;
        if (ccnt == OCOL_LAST) begin
          ccnt <= '0;
          rcnt <= (rcnt == OROW_LAST) ? '0 : rcnt + 1'b1;
        end else begin
          ccnt <= ccnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/win3_sweeper.sv
`timescale 1ns/1ps
module win3_sweeper
  import win3_pkg::*;
#(
  parameter  int IMG_W  = 640,
  parameter  int IMG_H  = 480,
  localparam int ADDR_W = $clog2(IMG_W * IMG_H),
  localparam int COL_W  = $clog2(IMG_W),
  localparam int ROW_W  = $clog2(IMG_H)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rd_data,
  output logic              win_valid,
  output logic [63:0]       win_pixels,
  output logic [COL_W-1:0]  out_col,
  output logic [ROW_W-1:0]  out_row,
  output logic              done
);
  rd_tag_t     req_tag;
  logic [63:0] nbr;
  logic        emit;

  win3_fetch_seq #(
    .IMG_W(IMG_W), .IMG_H(IMG_H), .ADDR_W(ADDR_W), .COL_W(COL_W), .ROW_W(ROW_W)
  ) u_fetch (
    .clk(clk), .rst(rst), .start(start), .sweep_end(done),
    .mem_addr(mem_addr), .tag_o(req_tag)
  );

  win3_window u_window (
    .clk(clk), .rst(rst), .tag_i(req_tag), .rd_data(mem_rd_data),
    .nbr_o(nbr), .emit_o(emit)
  );

  win3_emit #(
    .IMG_W(IMG_W), .IMG_H(IMG_H), .COL_W(COL_W), .ROW_W(ROW_W)
  ) u_emit (
    .clk(clk), .rst(rst), .emit_i(emit), .nbr_i(nbr),
    .win_valid(win_valid), .win_pixels(win_pixels),
    .out_col(out_col), .out_row(out_row), .done(done)
  );
endmodule

// File: rtl/win3_sweeper_chk.sv
`timescale 1ns/1ps
module win3_sweeper_chk #(
  parameter int IMG_W = 640,
  parameter int IMG_H = 480,
  parameter int ADDR_W = $clog2(IMG_W * IMG_H),
  parameter int COL_W = $clog2(IMG_W),
  parameter int ROW_W = $clog2(IMG_H)
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              win_valid,
  input logic [COL_W-1:0]  out_col,
  input logic [ROW_W-1:0]  out_row,
  input logic              done
);
  localparam logic [ADDR_W:0]  FRAME_SZ  = (ADDR_W + 1)'(IMG_W * IMG_H);
  localparam logic [COL_W-1:0] OCOL_LAST = COL_W'(IMG_W - 3);
  localparam logic [ROW_W-1:0] OROW_LAST = ROW_W'(IMG_H - 3);

  logic             seen;
  logic [COL_W-1:0] prev_col;
  logic [ROW_W-1:0] prev_row;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen     <= 1'b0;
      prev_col <= '0;
      prev_row <= '0;
    end else if (win_valid) begin
      seen     <= 1'b1;
      prev_col <= out_col;
      prev_row <= out_row;
    end
  end

  assert_addr_in_frame_R2: assert property (@(posedge clk) disable iff (rst)
    {1'b0, mem_addr} < FRAME_SZ);

  assert_coord_bounds_R4: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> (out_col <= OCOL_LAST) && (out_row <= OROW_LAST));

  assert_raster_step_R4: assert property (@(posedge clk) disable iff (rst)
    (win_valid && seen) |->
      ((out_row == prev_row) && (out_col == prev_col + 1'b1)) ||
      ((out_col == '0) && (prev_col == OCOL_LAST) &&
       ((out_row == prev_row + 1'b1) || ((out_row == '0) && (prev_row == OROW_LAST)))));

  assert_window_spacing_R8: assert property (@(posedge clk) disable iff (rst)
    win_valid |=> !win_valid);

  assert_done_after_last_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(win_valid) && ($past(out_col) == OCOL_LAST) && ($past(out_row) == OROW_LAST));

  assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

bind win3_sweeper win3_sweeper_chk #(.IMG_W(IMG_W), .IMG_H(IMG_H)) u_chk (
  .clk(clk), .rst(rst), .mem_addr(mem_addr), .win_valid(win_valid),
  .out_col(out_col), .out_row(out_row), .done(done)
);

// File: tb/win3_sweeper_bench.sv
`timescale 1ns/1ps
module win3_sweeper_bench;
  localparam int W  = 9;
  localparam int H  = 6;
  localparam int AW = $clog2(W * H);
  localparam int CW = $clog2(W);
  localparam int RW = $clog2(H);

  logic          clk = 1'b0;
  logic          rst;
  logic          start;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_rd_data;
  logic          win_valid;
  logic [63:0]   win_pixels;
  logic [CW-1:0] out_col;
  logic [RW-1:0] out_row;
  logic          done;

  logic [7:0] img [W*H];
  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  always_ff @(posedge clk) mem_rd_data <= img[mem_addr];

  win3_sweeper #(.IMG_W(W), .IMG_H(H)) u_win3_sweeper (
    .clk(clk), .rst(rst), .start(start), .mem_addr(mem_addr),
    .mem_rd_data(mem_rd_data), .win_valid(win_valid), .win_pixels(win_pixels),
    .out_col(out_col), .out_row(out_row), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // neighbour i of output coordinate (c, r), ordering of R3
  function automatic int nbr_pix(input int c, input int r, input int i);
    int dr, dc;
    case (i)
      0: begin dr = -1; dc = -1; end
      1: begin dr = -1; dc =  0; end
      2: begin dr = -1; dc =  1; end
      3: begin dr =  0; dc = -1; end
      4: begin dr =  0; dc =  1; end
      5: begin dr =  1; dc = -1; end
      6: begin dr =  1; dc =  0; end
      default: begin dr = 1; dc = 1; end
    endcase
    return int'(img[(r + 1 + dr) * W + (c + 1 + dc)]);
  endfunction

  task automatic fill(input int mode);
    for (int a = 0; a < W * H; a++) begin
      case (mode)
        1: img[a] = 8'h00;
        2: img[a] = 8'hFF;
        3: img[a] = 8'((a / W) * 40 + (a % W) * 7);
        default: img[a] = 8'($urandom);
      endcase
    end
  endtask

  task automatic sweep(input bit poke_start);
    int cyc, last_v, n, ec, er;
    bit got_done;
    cyc = 0; last_v = 0; n = 0; ec = 0; er = 0; got_done = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (!got_done && cyc < 3000) begin
      @(negedge clk);
      cyc++;
      start = poke_start && (cyc == 30 || cyc == 70);
      check(int'(mem_addr) < W * H, "R2 address in frame", int'(mem_addr), W * H - 1);
      if (win_valid) begin
        check(int'(out_col) == ec, "R4 column", int'(out_col), ec);
        check(int'(out_row) == er, "R4 row", int'(out_row), er);
        for (int i = 0; i < 8; i++)
          check(int'(win_pixels[i*8 +: 8]) == nbr_pix(ec, er, i), "R3 neighbour",
                int'(win_pixels[i*8 +: 8]), nbr_pix(ec, er, i));
        if (n > 0)
          check(cyc - last_v == ((ec == 0) ? 9 : 3), "R8 window gap",
                cyc - last_v, (ec == 0) ? 9 : 3);
        last_v = cyc;
        n++;
        if (ec == W - 3) begin ec = 0; er++; end
        else ec++;
      end
      if (done) begin
        got_done = 1;
        check(cyc == last_v + 1, "R6 done after last window", cyc - last_v, 1);
        check(n == (W - 2) * (H - 2), "R5 window count", n, (W - 2) * (H - 2));
        start = 1'b1;  // R7: start in the done cycle is ignored
      end
    end
    check(got_done, "R6 done seen", int'(got_done), 1);
    @(negedge clk) start = 1'b0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      check(!win_valid && !done, "R7 quiet after done", int'(win_valid), 0);
    end
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1;
    start = 1'b0;
    fill(0);
    repeat (3) @(negedge clk);
    check(!win_valid, "R1 valid low in reset", int'(win_valid), 0);
    check(!done, "R1 done low in reset", int'(done), 0);
    check(mem_addr == '0, "R1 address zero in reset", int'(mem_addr), 0);
    rst = 1'b0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      check(!win_valid && !done, "R1 idle without start", int'(win_valid), 0);
    end
    sweep(1'b0);
    fill(1); sweep(1'b0);
    fill(2); sweep(1'b1);
    fill(3); sweep(1'b0);
    for (int s = 0; s < 6; s++) begin
      fill(0);
      repeat (int'($urandom % 5)) @(negedge clk);
      sweep(s[0]);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule